// File: doc/BRIEF.md
# Two-Profile Numerically Controlled Oscillator

This block is a numerically controlled oscillator. It has a 28-bit phase accumulator that advances once per clock by one of two frequency tuning words. The top twelve accumulator bits are offset by one of two 12-bit phase words. The resulting phase is then shaped into a 10-bit offset-binary amplitude code and a 1-bit square output. The output frequency is the tuning word times the clock rate over 2^28. A tuning word above 2^27, which is half the clock rate, is not a valid setting. One phase-word LSB is 1/4096 of a turn.

The amplitude can be a sine or a triangle. The sine comes from a 256-entry quarter-wave table that is computed at elaboration and folded by symmetry. The square output can follow the phase MSB directly or toggle at half that rate. It is held low while the triangle shape is selected, because that pairing is reserved.

The profile selectors can switch at any time without disturbing the accumulator. This gives phase-continuous frequency or phase keying. A clear input zeroes the accumulator and holds it at zero, so the outputs then depend only on the selected phase word.

Top module: `nco_wave_gen`

## Requirements
- R1: On every clock edge with accClr low, the accumulator advances by the selected tuning word, modulo 2^28.
- R2: The selected phase word is added to accumulator bits 27:16, giving a 12-bit phase s; one phase LSB is 1/4096 turn.
- R3: While accClr is high, the accumulator is zero and stays zero, so the outputs depend only on the selected phase word and mode; freqSel has no effect then.
- R4: In sine mode (triMode=0), ampOut is within 2 codes of B+round(511*sin(2*pi*(4*floor(s/4)+2)/4096)), where B=512 when s[11]=0 and B=511 otherwise.
- R5: In triangle mode (triMode=1), ampOut equals s[10:1] when s[11]=0, and the bitwise inverse of s[10:1] when s[11]=1.
- R6: With sqEn=1, triMode=0 and sqHalf=0, sqOut equals s[11].
- R7: With sqEn=1, triMode=0 and sqHalf=1, sqOut toggles once for every 0-to-1 change of s[11], so each of its high and low runs is twice as long as in R6.
- R8: sqOut is 0 whenever triMode=1 or sqEn=0.
- R9: Changing freqSel never clears the accumulator; the phase continues from its current value at the new rate.
- R10: phaseSel=1 selects phaseWord1 and phaseSel=0 selects phaseWord0; freqSel=1 selects freqWord1 and freqSel=0 selects freqWord0.
- R11: A change of phase word, selector or mode that is present at a clock edge shows on the outputs after exactly two rising edges; the accumulator value formed at an edge shows two edges later.
- R12: While rstN is low, ampOut and sqOut are 0 and the accumulator is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accClr | input | 1 | Clears the accumulator and holds it at zero |
| freqWord0 | input | 28 | Tuning word of profile 0 |
| freqWord1 | input | 28 | Tuning word of profile 1 |
| phaseWord0 | input | 12 | Phase offset of profile 0 |
| phaseWord1 | input | 12 | Phase offset of profile 1 |
| freqSel | input | 1 | Tuning word select |
| phaseSel | input | 1 | Phase offset select |
| triMode | input | 1 | 1 selects triangle, 0 selects sine |
| sqEn | input | 1 | Enables the square output |
| sqHalf | input | 1 | 1 makes the square output toggle at half the phase MSB rate |
| ampOut | output | 10 | Offset-binary amplitude code |
| sqOut | output | 1 | Square output |

## Verification
A frequency profile switch and an accumulator step fall on the same clock edge. The bench provokes this by changing freqSel in the middle of a triangle ramp whose slope is one code per cycle. Over the following edges it expects the exact codes 32, 33, 35 and then a slope of two, which shows that the ramp neither restarts nor skips. Triangle selection and square enable also coincide in one cycle. That case is judged by requiring the square output to stay low while the accumulator runs, after which clearing triMode must restore runs of exactly 8 cycles.

// File: rtl/nco_pkg.sv
package nco_pkg;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic clrAcc;   // accumulator clear, same cycle
    logic triOn;    // triangle shape, aligned with the phase stage
    logic sqOn;     // square output allowed, aligned with the phase stage
    logic sqHalf;   // halved square rate, aligned with the phase stage
  } ncoStrobesT;

  // Quarter-wave sample for table index idx, rational sine approximation
  // evaluated at the bin centre; result scaled to 0..peak.
  function automatic logic [15:0] quarterSine(input int idx, input int idxBits, input int peak);
    longint p, h, pq, num, den;
    p   = 2 * longint'(idx) + 1;
    h   = longint'(4) << idxBits;
    pq  = p * (h - p);
    num = 16 * pq * longint'(peak);
    den = 5 * h * h - 4 * pq;
    return 16'((num + den / 2) / den);
  endfunction

endpackage

// File: rtl/nco_ctrl.sv
module nco_ctrl
  import nco_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accClr,
  input  logic [ACC_W-1:0] freqWord0,
  input  logic [ACC_W-1:0] freqWord1,
  input  logic [PH_W-1:0]  phaseWord0,
  input  logic [PH_W-1:0]  phaseWord1,
  input  logic             freqSel,
  input  logic             phaseSel,
  input  logic             triMode,
  input  logic             sqEn,
  input  logic             sqHalf,
  output logic [ACC_W-1:0] freqStep,
  output logic [PH_W-1:0]  phaseOfs,
  output ncoStrobesT       strobes
);

  logic triQ, sqOnQ, halfQ;

  assign freqStep = freqSel  ? freqWord1  : freqWord0;
  assign phaseOfs = phaseSel ? phaseWord1 : phaseWord0;

  // Mode bits are registered so they travel with the phase-sum stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      triQ  <= 1'b0;
      sqOnQ <= 1'b0;
      halfQ <= 1'b0;
    end else begin
      triQ  <= triMode;
      sqOnQ <= sqEn & ~triMode;   // reserved pairing: triangle blocks square
      halfQ <= sqHalf;
    end
  end

  always_comb begin
    strobes.clrAcc = accClr;
    strobes.triOn  = triQ;
    strobes.sqOn   = sqOnQ;
    strobes.sqHalf = halfQ;
  end

endmodule

// File: rtl/nco_datapath.sv
module nco_datapath
  import nco_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  ncoStrobesT       strobes,
  input  logic [ACC_W-1:0] freqStep,
  input  logic [PH_W-1:0]  phaseOfs,
  output logic [PH_W-3:0]  ampOut,
  output logic             sqOut
);

  localparam int AMP_W     = PH_W - 2;
  localparam int LUT_AW    = PH_W - 4;
  localparam int LUT_DEPTH = 1 << LUT_AW;
  localparam int PEAK      = (1 << (AMP_W - 1)) - 1;
  localparam int TOP_LSB   = ACC_W - PH_W;

  logic [ACC_W-1:0]  acc;
  logic [PH_W-2:0]   sumHi;     // phase sum without its LSB
  logic [PH_W-2:0]   sumQ;
  logic              sumCarry;
  logic [AMP_W-2:0]  lutRom [LUT_DEPTH];
  logic [LUT_AW-1:0] lutIdx;
  logic [AMP_W-2:0]  lutVal;
  logic [AMP_W-1:0]  sineVal, triVal;
  logic              phMsb, msbPrev, divT, divNew;

  // Quarter-wave table built at elaboration
  for (genvar gi = 0; gi < LUT_DEPTH; gi++) begin : g_lut
    localparam logic [15:0] RAW = quarterSine(gi, LUT_AW, PEAK);
    assign lutRom[gi] = RAW[AMP_W-2:0];
  end

  // Phase accumulator
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               acc <= '0;
    else if (strobes.clrAcc) acc <= '0;
    else                     acc <= acc + freqStep;
  end

  // Offset added to the top bits; only the carry of the lowest bit is kept
  assign sumCarry = acc[TOP_LSB] & phaseOfs[0];
  assign sumHi    = acc[ACC_W-1:TOP_LSB+1] + phaseOfs[PH_W-1:1]
                  + {{(PH_W-2){1'b0}}, sumCarry};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sumQ <= '0;
    else       sumQ <= sumHi;
  end

  // Shaping
  assign phMsb   = sumQ[PH_W-2];
  assign lutIdx  = sumQ[PH_W-3] ? ~sumQ[PH_W-4 -: LUT_AW] : sumQ[PH_W-4 -: LUT_AW];
  assign lutVal  = lutRom[lutIdx];
  assign sineVal = phMsb ? {1'b0, ~lutVal} : {1'b1, lutVal};
  assign triVal  = phMsb ? ~sumQ[PH_W-3:0] : sumQ[PH_W-3:0];
  assign divNew  = divT ^ (phMsb & ~msbPrev);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ampOut  <= '0;
      sqOut   <= 1'b0;
      msbPrev <= 1'b0;
      divT    <= 1'b0;
    end else begin
      ampOut  <= strobes.triOn ? triVal : sineVal;
      msbPrev <= phMsb;
      divT    <= divNew;
      sqOut   <= strobes.sqOn & (strobes.sqHalf ? divNew : phMsb);
    end
  end

endmodule

// File: rtl/nco_wave_gen.sv
module nco_wave_gen
  import nco_pkg::*;
#(
  parameter int ACC_W = 28,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accClr,
  input  logic [ACC_W-1:0] freqWord0,
  input  logic [ACC_W-1:0] freqWord1,
  input  logic [PH_W-1:0]  phaseWord0,
  input  logic [PH_W-1:0]  phaseWord1,
  input  logic             freqSel,
  input  logic             phaseSel,
  input  logic             triMode,
  input  logic             sqEn,
  input  logic             sqHalf,
  output logic [PH_W-3:0]  ampOut,
  output logic             sqOut
);

  ncoStrobesT       strobes;
  logic [ACC_W-1:0] freqStep;
  logic [PH_W-1:0]  phaseOfs;

  nco_ctrl #(.ACC_W(ACC_W), .PH_W(PH_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .accClr(accClr),
    .freqWord0(freqWord0), .freqWord1(freqWord1),
    .phaseWord0(phaseWord0), .phaseWord1(phaseWord1),
    .freqSel(freqSel), .phaseSel(phaseSel),
    .triMode(triMode), .sqEn(sqEn), .sqHalf(sqHalf),
    .freqStep(freqStep), .phaseOfs(phaseOfs), .strobes(strobes)
  );

  nco_datapath #(.ACC_W(ACC_W), .PH_W(PH_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .freqStep(freqStep), .phaseOfs(phaseOfs),
    .ampOut(ampOut), .sqOut(sqOut)
  );

endmodule

// File: rtl/nco_wave_gen_chk.sv
module nco_wave_gen_chk #(
  parameter int PH_W = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            accClr,
  input logic            phaseSel,
  input logic [PH_W-1:0] phaseWord0,
  input logic [PH_W-1:0] phaseWord1,
  input logic            triMode,
  input logic            sqEn,
  input logic [PH_W-3:0] ampOut,
  input logic            sqOut
);

  logic [2:0] cyc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cyc <= '0;
    else if (cyc != 3'd7) cyc <= cyc + 3'd1;
  end

  // R8
  sq_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 3'd2 && $past(triMode, 2)) |-> !sqOut);

  // R8
  sq_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 3'd2 && !$past(sqEn, 2)) |-> !sqOut);

  // R3
  clr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cyc >= 3'd5 && $past(accClr, 3) && $past(accClr, 4)
     && $past(phaseSel, 2) == $past(phaseSel, 3)
     && $past(phaseWord0, 2) == $past(phaseWord0, 3)
     && $past(phaseWord1, 2) == $past(phaseWord1, 3)
     && $past(triMode, 2) == $past(triMode, 3)) |-> $stable(ampOut));

  // R12
  always @(posedge clk) begin
    if (!rstN) begin
      rst_out_chk: assert (ampOut == '0 && !sqOut);
    end
  end

endmodule

bind nco_wave_gen nco_wave_gen_chk #(.PH_W(PH_W)) chk_i (
  .clk(clk), .rstN(rstN), .accClr(accClr), .phaseSel(phaseSel),
  .phaseWord0(phaseWord0), .phaseWord1(phaseWord1),
  .triMode(triMode), .sqEn(sqEn), .ampOut(ampOut), .sqOut(sqOut)
);

// File: tb/nco_wave_gen_tb_top.sv
`timescale 1ns/1ps
module nco_wave_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        accClr = 1'b1;
  logic [27:0] freqWord0 = '0, freqWord1 = '0;
  logic [11:0] phaseWord0 = '0, phaseWord1 = '0;
  logic        freqSel = 1'b0, phaseSel = 1'b0;
  logic        triMode = 1'b0, sqEn = 1'b0, sqHalf = 1'b0;
  logic [9:0]  ampOut;
  logic        sqOut;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;   // 125 MHz

  nco_wave_gen dut_i (
    .clk(clk), .rstN(rstN), .accClr(accClr),
    .freqWord0(freqWord0), .freqWord1(freqWord1),
    .phaseWord0(phaseWord0), .phaseWord1(phaseWord1),
    .freqSel(freqSel), .phaseSel(phaseSel),
    .triMode(triMode), .sqEn(sqEn), .sqHalf(sqHalf),
    .ampOut(ampOut), .sqOut(sqOut)
  );

  // Vector: {tri, sqEn, phase[11:0], expAmp[9:0], expSq, isSine}
  localparam int NVEC = 13;
  localparam logic [25:0] VECS [NVEC] = '{
    {1'b1, 1'b1, 12'h000, 10'd0,    1'b0, 1'b0},
    {1'b1, 1'b0, 12'h002, 10'd1,    1'b0, 1'b0},
    {1'b1, 1'b0, 12'h7FE, 10'd1023, 1'b0, 1'b0},
    {1'b1, 1'b1, 12'h800, 10'd1023, 1'b0, 1'b0},
    {1'b1, 1'b0, 12'hC00, 10'd511,  1'b0, 1'b0},
    {1'b1, 1'b0, 12'hFFE, 10'd0,    1'b0, 1'b0},
    {1'b1, 1'b1, 12'h400, 10'd512,  1'b0, 1'b0},
    {1'b0, 1'b1, 12'h000, 10'd0,    1'b0, 1'b1},
    {1'b0, 1'b1, 12'h400, 10'd0,    1'b0, 1'b1},
    {1'b0, 1'b1, 12'h800, 10'd0,    1'b1, 1'b1},
    {1'b0, 1'b1, 12'hC00, 10'd0,    1'b1, 1'b1},
    {1'b0, 1'b0, 12'h900, 10'd0,    1'b0, 1'b1},
    {1'b0, 1'b1, 12'h155, 10'd0,    1'b0, 1'b1}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic int sineRef(input logic [11:0] w);
    real th, v;
    int  base;
    th   = 2.0 * 3.14159265358979 * real'(4 * (int'(w) / 4) + 2) / 4096.0;
    v    = 511.0 * $sin(th);
    base = w[11] ? 511 : 512;
    return base + $rtoi(v >= 0.0 ? v + 0.5 : v - 0.5);
  endfunction

  // Measures square run lengths after settling (R6, R7)
  task automatic checkRuns(input int expLen, input string tag);
    int   runLen = 0;
    int   seen   = 0;
    logic last;
    waitNeg(40);
    last = sqOut;
    for (int k = 0; k < 130; k++) begin
      @(negedge clk);
      if (sqOut != last) begin
        if (seen > 0) check(runLen == expLen, tag, runLen, expLen);
        seen++;
        runLen = 1;
        last   = sqOut;
      end else begin
        runLen++;
      end
    end
    check(seen >= 3, {tag, " transitions"}, seen, 3);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int amp, prev, ones;
    // R12: outputs at zero while reset is held
    waitNeg(3);
    check(ampOut == 10'd0, "R12 ampOut in reset", ampOut, 0);
    check(sqOut == 1'b0, "R12 sqOut in reset", sqOut, 0);
    rstN = 1'b1;
    waitNeg(2);

    // R2 R4 R5 R8: static phase vectors with the accumulator held clear
    for (int v = 0; v < NVEC; v++) begin
      triMode    = VECS[v][25];
      sqEn       = VECS[v][24];
      phaseWord0 = VECS[v][23:12];
      waitNeg(3);
      if (VECS[v][0]) begin
        amp = sineRef(VECS[v][23:12]);
        check((int'(ampOut) - amp <= 2) && (amp - int'(ampOut) <= 2),
              "R4 sine code", ampOut, amp);
      end else begin
        check(ampOut == VECS[v][11:2], "R5 triangle code", ampOut, VECS[v][11:2]);
      end
      check(sqOut == VECS[v][1], "R6 R8 static square", sqOut, VECS[v][1]);
    end

    // R10: phase profile select, R3: freqSel has no effect while clear held
    triMode = 1'b1; sqEn = 1'b0;
    phaseWord0 = 12'h100; phaseWord1 = 12'h600;
    freqWord0 = 28'h0100000; freqWord1 = 28'h0400000;
    phaseSel = 1'b1; waitNeg(3);
    check(ampOut == 10'd768, "R10 phaseSel=1", ampOut, 768);
    phaseSel = 1'b0; waitNeg(3);
    check(ampOut == 10'd128, "R10 phaseSel=0", ampOut, 128);
    freqSel = 1'b1; waitNeg(3);
    check(ampOut == 10'd128, "R3 freqSel ignored in clear", ampOut, 128);
    freqSel = 1'b0;

    // R11: phase change appears after exactly two rising edges
    phaseWord0 = 12'h000; waitNeg(3);
    phaseWord0 = 12'h400;
    waitNeg(1);
    check(ampOut == 10'd0, "R11 one edge, old value", ampOut, 0);
    waitNeg(1);
    check(ampOut == 10'd512, "R11 two edges, new value", ampOut, 512);

    // R1 R11 R9: triangle ramp, then on-the-fly profile switch
    phaseWord0 = 12'h000;
    freqWord0  = 28'h0020000;   // s advances 2 per cycle
    freqWord1  = 28'h0040000;   // s advances 4 per cycle
    waitNeg(3);
    accClr = 1'b0;
    waitNeg(3);
    check(ampOut == 10'd1, "R1 R11 first ramp code", ampOut, 1);
    prev = ampOut;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      check(int'(ampOut) == prev + 1, "R1 ramp slope 1", ampOut, prev + 1);
      prev = ampOut;
    end
    freqSel = 1'b1;
    waitNeg(1);
    check(ampOut == 10'd32, "R9 switch edge+1", ampOut, 32);
    waitNeg(1);
    check(ampOut == 10'd33, "R9 switch edge+2", ampOut, 33);
    waitNeg(1);
    check(ampOut == 10'd35, "R9 switch edge+3", ampOut, 35);
    prev = ampOut;
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      check(int'(ampOut) == prev + 2, "R1 R9 ramp slope 2", ampOut, prev + 2);
      prev = ampOut;
    end

    // R3: clear during running
    freqSel = 1'b0; freqWord0 = 28'h0100000; phaseWord0 = 12'h100;
    waitNeg(20);
    accClr = 1'b1;
    waitNeg(3);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check(ampOut == 10'd128, "R3 held clear", ampOut, 128);
    end

    // R6 R7 R8: square output while running, s[11] period 16 cycles
    phaseWord0 = 12'h000; freqWord0 = 28'h1000000;
    triMode = 1'b0; sqEn = 1'b1; sqHalf = 1'b0; accClr = 1'b0;
    checkRuns(8, "R6 direct run length");
    sqHalf = 1'b1;
    checkRuns(16, "R7 halved run length");
    sqHalf = 1'b0; triMode = 1'b1;
    waitNeg(3);
    ones = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (sqOut) ones++;
    end
    check(ones == 0, "R8 triangle blocks square", ones, 0);
    triMode = 1'b0; sqEn = 1'b0;
    waitNeg(3);
    ones = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (sqOut) ones++;
    end
    check(ones == 0, "R8 square disabled", ones, 0);
    sqEn = 1'b1;
    checkRuns(8, "R8 R6 square restored");

    // R12: asynchronous reset mid-run
    @(posedge clk); #1;
    rstN = 1'b0;
    #1;
    check(ampOut == 10'd0 && sqOut == 1'b0, "R12 async reset", {sqOut, ampOut}, 0);
    waitNeg(2);
    finishRun();
  end

endmodule